// File: doc/BRIEF.md
# Dual-Output Serial Flash Burst Reader

This block is the host side of a burst read from a serial flash that returns data on two lines at once. A caller presents a start address and a byte count, then pulses `start`. The block selects the flash and clocks out the read command. The command is the opcode 3Bh, a 24-bit address and one dummy byte. The block then stops driving its data line and collects two data bits on every serial clock, using both the input line and the former output line. Each rebuilt byte is handed downstream on a valid/ready stream. A single-cycle `done` pulse marks the end of the burst.

One serial clock period lasts `CLK_DIV` system clocks. The idle level of SCK is set by a parameter: low for mode 0, high for mode 3. When the downstream side stops accepting bytes, the block holds the serial clock low. No byte is dropped and the flash does not run ahead. A burst keeps running under a single chip select even when it passes the top of the flash array. In that case the flash itself wraps the address back to zero.

Top module: `dual_read_ctrl`

## Requirements
- R1: While reset is held, and after it is released, `cs_n` is 1, `sio0_oe` is 0, and `rd_valid`, `done` and `busy` are 0.
- R2: A start with a nonzero count lowers `cs_n` and shifts 40 bits out on `sio0_o`, most significant bit first: opcode 3Bh, then address bits 23 down to 0, then eight zero bits. `sio0_oe` is 1 during these bits.
- R3: Each SCK period is exactly `CLK_DIV` system clocks, low for `CLK_DIV/2` and high for the rest, except while the block is stalled. While selected, `sio0_o` changes only on a falling SCK edge.
- R4: `sio0_oe` rises only together with the fall of `cs_n`. It drops on the falling SCK edge that ends the 40th command clock, and it stays 0 for every data clock.
- R5: Each byte is taken from four rising SCK edges. At each edge, `sio1_i` supplies the next odd bit (7, 5, 3, 1) and `sio0_i` supplies the next even bit (6, 4, 2, 0).
- R6: A byte held with `rd_valid` high and `rd_ready` low stays on `rd_data` unchanged until the cycle after `rd_ready` is 1.
- R7: When the output byte is still waiting, SCK pauses before the rising edge that would complete the next byte. Exactly `byte_count` bytes are delivered, whatever pattern `rd_ready` follows.
- R8: A burst of N bytes keeps `cs_n` low for exactly 40 + 4·N rising SCK edges under one select. This also holds when the flash wraps from 7FFFFFh to 000000h partway through the burst.
- R9: `done` is a one-cycle pulse. It is issued in the cycle in which `cs_n` returns to 1, and `busy` is 0 in that cycle.
- R10: A start with a byte count of zero raises `done` in the next cycle, and `cs_n` never falls.
- R11: A `start` pulse while `busy` is 1 is ignored: no second select, and the running burst's address and count are kept.
- R12: While `cs_n` is 1, SCK sits at the idle level: 0 with `SCK_IDLE_HIGH` = 0, 1 with `SCK_IDLE_HIGH` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a burst (taken only when idle) |
| start_addr | input | ADDR_W | First byte address |
| byte_count | input | CNT_W | Number of bytes to fetch |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle end-of-burst pulse |
| sck | output | 1 | Serial clock to the flash |
| cs_n | output | 1 | Active-low chip select |
| sio0_o | output | 1 | Command/address bit to the flash |
| sio0_oe | output | 1 | Output enable for the shared line 0 |
| sio0_i | input | 1 | Line 0 as seen by the host (even data bits) |
| sio1_i | input | 1 | Line 1 from the flash (odd data bits) |
| rd_data | output | 8 | Rebuilt byte |
| rd_valid | output | 1 | Byte available |
| rd_ready | input | 1 | Downstream accepts the byte |

## Verification
The bench runs bursts that start one or two bytes below the top of the array. A design that restarted the command, or dropped the chip select at the wrap, would show an extra select or a wrong rising-edge count. Downstream back-pressure that is sparse, alternating or long exposes a design that overwrites a waiting byte, because the received count or content would be wrong. It also exposes a design that keeps clocking the flash during the wait, which would skip flash data. Swapped or reversed bit pairs corrupt every byte against the address-derived pattern. The bench also checks that the line is released on the correct clock, that zero-length requests never select the flash, and that a start pulse in mid-burst is ignored. It covers two dividers and both idle levels.

// File: rtl/dual_read_pkg.sv
package dual_read_pkg;
   localparam logic [7:0] DR_OPCODE     = 8'h3B;
   localparam int         DR_DUMMY_BITS = 8;
   localparam int         DR_PAIRS      = 4;

   typedef enum logic [1:0] {
      DR_IDLE = 2'd0,
      DR_CMD  = 2'd1,
      DR_DATA = 2'd2
   } dr_state_e;
endpackage

// File: rtl/dr_sck_gen.sv
module dr_sck_gen #(
   parameter int CLK_DIV   = 4,
   parameter bit IDLE_HIGH = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic run,
   input  logic rise_block,
   input  logic last,
   output logic rise_ev,
   output logic fall_end,
   output logic sck
);
   localparam int LO = CLK_DIV / 2;
   localparam int PW = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;

   if (CLK_DIV < 2) begin : g_div_chk
      $error("dr_sck_gen: CLK_DIV must be at least 2");
   end

   logic [PW-1:0] ph;
   logic          at_rise;
   logic          at_end;
   logic          adv;

   if (CLK_DIV == 2) begin : g_half
      assign at_rise = ~ph[0];
      assign at_end  = ph[0];
   end else begin : g_count
      assign at_rise = (ph == PW'(LO - 1));
      assign at_end  = (ph == PW'(CLK_DIV - 1));
   end

   assign adv      = run && !(rise_block && at_rise);
   assign rise_ev  = adv && at_rise;
   assign fall_end = adv && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph  <= '0;
         sck <= IDLE_HIGH;
      end else if (restart) begin
         ph  <= '0;
         sck <= 1'b0;
      end else if (fall_end) begin
         ph  <= '0;
         sck <= last ? IDLE_HIGH : 1'b0;
      end else if (adv) begin
         ph <= ph + PW'(1);
         if (rise_ev) sck <= 1'b1;
      end
   end
endmodule

// File: rtl/dr_cmd_shift.sv
module dr_cmd_shift
   import dual_read_pkg::*;
#(
   parameter int ADDR_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] addr,
   input  logic              shift,
   output logic              bit_o
);
   localparam int W = 8 + ADDR_W + DR_DUMMY_BITS;

   logic [W-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sh <= '0;
      else if (load)  sh <= {DR_OPCODE, addr, {DR_DUMMY_BITS{1'b0}}};
      else if (shift) sh <= {sh[W-2:0], 1'b0};
   end

   assign bit_o = sh[W-1];
endmodule

// File: rtl/dr_byte_pack.sv
module dr_byte_pack (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       capture,
   input  logic       last_pair,
   input  logic       hi_bit,
   input  logic       lo_bit,
   input  logic       rd_ready,
   output logic [7:0] rd_data,
   output logic       rd_valid
);
   logic [5:0] part;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         part     <= '0;
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         if (capture && last_pair) begin
            rd_data  <= {part, hi_bit, lo_bit};
            rd_valid <= 1'b1;
         end else if (rd_ready) begin
            rd_valid <= 1'b0;
         end
         if (capture) part <= {part[3:0], hi_bit, lo_bit};
      end
   end
endmodule

// File: rtl/dual_read_ctrl.sv
module dual_read_ctrl
   import dual_read_pkg::*;
#(
   parameter int CLK_DIV       = 4,
   parameter bit SCK_IDLE_HIGH = 1'b0,
   parameter int ADDR_W        = 24,
   parameter int CNT_W         = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [CNT_W-1:0]  byte_count,
   output logic              busy,
   output logic              done,
   output logic              sck,
   output logic              cs_n,
   output logic              sio0_o,
   output logic              sio0_oe,
   input  logic              sio0_i,
   input  logic              sio1_i,
   output logic [7:0]        rd_data,
   output logic              rd_valid,
   input  logic              rd_ready
);
   localparam int CMD_BITS = 8 + ADDR_W + DR_DUMMY_BITS;
   localparam int SLOT_W   = $clog2(CMD_BITS);
   localparam int PAIR_W   = $clog2(DR_PAIRS);

   if (ADDR_W != 24) begin : g_addr_chk
      $error("dual_read_ctrl: the read command carries a 24-bit address");
   end
   if (CNT_W < 1) begin : g_cnt_chk
      $error("dual_read_ctrl: CNT_W must be positive");
   end

   dr_state_e          state;
   logic [SLOT_W-1:0]  slot;
   logic [PAIR_W-1:0]  pair;
   logic [CNT_W-1:0]   left;
   logic               cs_r;
   logic               oe_r;
   logic               done_r;

   logic go;
   logic data_ph;
   logic last_pair;
   logic rise_ev;
   logic fall_end;
   logic rise_block;
   logic final_slot;

   assign go         = start && (state == DR_IDLE) && (byte_count != '0);
   assign data_ph    = (state == DR_DATA);
   assign last_pair  = (pair == PAIR_W'(DR_PAIRS - 1));
   assign rise_block = data_ph && last_pair && rd_valid && !rd_ready;
   assign final_slot = data_ph && last_pair && (left == '0);

   dr_sck_gen #(
      .CLK_DIV  (CLK_DIV),
      .IDLE_HIGH(SCK_IDLE_HIGH)
   ) u_sck (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (go),
      .run       (state != DR_IDLE),
      .rise_block(rise_block),
      .last      (final_slot),
      .rise_ev   (rise_ev),
      .fall_end  (fall_end),
      .sck       (sck)
   );

   dr_cmd_shift #(
      .ADDR_W(ADDR_W)
   ) u_cmd (
      .clk  (clk),
      .rst_n(rst_n),
      .load (go),
      .addr (start_addr),
      .shift(fall_end && (state == DR_CMD) && (slot != SLOT_W'(CMD_BITS - 1))),
      .bit_o(sio0_o)
   );

   dr_byte_pack u_pack (
      .clk      (clk),
      .rst_n    (rst_n),
      .capture  (rise_ev && data_ph),
      .last_pair(last_pair),
      .hi_bit   (sio1_i),
      .lo_bit   (sio0_i),
      .rd_ready (rd_ready),
      .rd_data  (rd_data),
      .rd_valid (rd_valid)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= DR_IDLE;
         slot   <= '0;
         pair   <= '0;
         left   <= '0;
         cs_r   <= 1'b1;
         oe_r   <= 1'b0;
         done_r <= 1'b0;
      end else begin
         done_r <= 1'b0;
         unique case (state)
            DR_IDLE: begin
               if (start) begin
                  if (byte_count == '0) begin
                     done_r <= 1'b1;
                  end else begin
                     state <= DR_CMD;
                     cs_r  <= 1'b0;
                     oe_r  <= 1'b1;
                     slot  <= '0;
                     pair  <= '0;
                     left  <= byte_count;
                  end
               end
            end
            DR_CMD: begin
               if (fall_end) begin
                  if (slot == SLOT_W'(CMD_BITS - 1)) begin
                     state <= DR_DATA;
                     oe_r  <= 1'b0;
                  end else begin
                     slot <= slot + SLOT_W'(1);
                  end
               end
            end
            DR_DATA: begin
               if (rise_ev && last_pair) left <= left - CNT_W'(1);
               if (fall_end) begin
                  pair <= pair + PAIR_W'(1);
                  if (final_slot) begin
                     state  <= DR_IDLE;
                     cs_r   <= 1'b1;
                     done_r <= 1'b1;
                  end
               end
            end
            default: state <= DR_IDLE;
         endcase
      end
   end

   assign busy    = (state != DR_IDLE);
   assign done    = done_r;
   assign cs_n    = cs_r;
   assign sio0_oe = oe_r;
endmodule

// File: rtl/dual_read_ctrl_chk.sv
module dual_read_ctrl_chk #(
   parameter bit SCK_IDLE_HIGH = 1'b0,
   parameter int CNT_W         = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [CNT_W-1:0] byte_count,
   input logic             busy,
   input logic             done,
   input logic             sck,
   input logic             cs_n,
   input logic             sio0_o,
   input logic             sio0_oe,
   input logic [7:0]       rd_data,
   input logic             rd_valid,
   input logic             rd_ready
);
   a_r12_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> (sck == SCK_IDLE_HIGH));

   a_r3_out_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && $past(!cs_n) && sio0_oe && (sio0_o != $past(sio0_o)))
         |-> ($past(sck) && !sck));

   a_r4_oe_with_select: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sio0_oe) |-> $fell(cs_n));

   a_r4_release_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sio0_oe) |-> ($fell(sck) && !cs_n));

   a_r6_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

   a_r9_done_at_deselect: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> (done && !busy));

   a_r9_done_deselected: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cs_n && !busy));

   a_r10_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && (byte_count == '0)) |=> (done && cs_n));

   a_r11_select_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> ($past(start) && !$past(busy)));
endmodule

bind dual_read_ctrl dual_read_ctrl_chk #(
   .SCK_IDLE_HIGH(SCK_IDLE_HIGH),
   .CNT_W        (CNT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .byte_count(byte_count),
   .busy      (busy),
   .done      (done),
   .sck       (sck),
   .cs_n      (cs_n),
   .sio0_o    (sio0_o),
   .sio0_oe   (sio0_oe),
   .rd_data   (rd_data),
   .rd_valid  (rd_valid),
   .rd_ready  (rd_ready)
);

// File: tb/test_dual_read_ctrl.sv
`timescale 1ns/1ps

function automatic logic [7:0] tb_mem_byte(input logic [22:0] a);
   logic [7:0] m;
   m = a[7:0] * 8'd7;
   return m ^ a[15:8] ^ {1'b0, a[22:16]};
endfunction

module tb_flash_model (
   input  logic cs_n,
   input  logic sck,
   input  logic si,
   input  logic si_oe,
   output logic so0,
   output logic so1
);
   logic [39:0] sh;
   logic [7:0]  op;
   logic [23:0] addr;
   logic [22:0] ptr;
   logic [7:0]  cur;
   int          rises;
   int          selects;
   int          oe_err;
   int          pair;
   realtime     min_gap;
   realtime     last_t;
   bit          have_last;

   initial begin
      so0 = 1'b0; so1 = 1'b0; selects = 0; oe_err = 0; rises = 0;
      min_gap = 1.0e9; have_last = 1'b0; pair = 0; ptr = '0;
      op = '0; addr = '0; sh = '0; last_t = 0.0; cur = '0;
   end

   always @(negedge cs_n) begin
      rises = 0; selects++; sh = '0; pair = 0; have_last = 1'b0;
   end

   always @(posedge sck) begin
      if (!cs_n) begin
         if (have_last && ($realtime - last_t) < min_gap) min_gap = $realtime - last_t;
         last_t = $realtime; have_last = 1'b1;
         if (rises < 40) begin
            sh = {sh[38:0], si};
            if (!si_oe) oe_err++;
         end
         rises++;
         if (rises == 40) begin
            op = sh[39:32]; addr = sh[31:8]; ptr = sh[30:8]; pair = 0;
         end
      end
   end

   always @(negedge sck) begin
      #1;
      if (!cs_n && rises >= 40) begin
         cur = tb_mem_byte(ptr);
         so1 = cur[7 - 2*pair];
         so0 = cur[6 - 2*pair];
         if (si_oe) oe_err++;
         if (pair == 3) begin pair = 0; ptr = ptr + 23'd1; end
         else pair++;
      end
   end
endmodule

module test_dual_read_ctrl;
   localparam int DIV0 = 4;
   localparam int DIV1 = 3;

   // {ready pattern[1:0], start address[23:0], byte count[15:0]}
   localparam logic [41:0] VECS [6] = '{
      {2'd0, 24'h000000, 16'd1},
      {2'd0, 24'h123456, 16'd5},
      {2'd1, 24'h0ABCDE, 16'd8},
      {2'd0, 24'h7FFFFE, 16'd4},
      {2'd2, 24'h3FFFF0, 16'd20},
      {2'd1, 24'h7FFFFF, 16'd3}
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic        start;
   logic [23:0] start_addr;
   logic [15:0] byte_count;
   logic        rd_ready;

   logic busy0, done0, sck0, csn0, so0, oe0, si0_0, si1_0, valid0;
   logic busy1, done1, sck1, csn1, so1, oe1, si0_1, si1_1, valid1;
   logic [7:0] data0, data1;

   int tests = 0;
   int fails = 0;
   int cyc   = 0;

   always #2.5 clk = ~clk;

   dual_read_ctrl #(.CLK_DIV(DIV0), .SCK_IDLE_HIGH(1'b0)) i_dual_read_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
      .byte_count(byte_count), .busy(busy0), .done(done0), .sck(sck0),
      .cs_n(csn0), .sio0_o(so0), .sio0_oe(oe0), .sio0_i(si0_0), .sio1_i(si1_0),
      .rd_data(data0), .rd_valid(valid0), .rd_ready(rd_ready));

   dual_read_ctrl #(.CLK_DIV(DIV1), .SCK_IDLE_HIGH(1'b1)) i_dual_read_ctrl_m3 (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
      .byte_count(byte_count), .busy(busy1), .done(done1), .sck(sck1),
      .cs_n(csn1), .sio0_o(so1), .sio0_oe(oe1), .sio0_i(si0_1), .sio1_i(si1_1),
      .rd_data(data1), .rd_valid(valid1), .rd_ready(rd_ready));

   tb_flash_model m0 (.cs_n(csn0), .sck(sck0), .si(so0), .si_oe(oe0), .so0(si0_0), .so1(si1_0));
   tb_flash_model m1 (.cs_n(csn1), .sck(sck1), .si(so1), .si_oe(oe1), .so0(si0_1), .so1(si1_1));

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic verify(input string inst, input int div, input bit idle_hi,
                         input logic [23:0] a, input int n, input int got, input int donec,
                         input logic [7:0] b [64], input int sel_delta,
                         input logic [7:0] op, input logic [23:0] ad, input int rises,
                         input int oe_err, input realtime gap, input logic sck_now,
                         input logic csn_now, input bit restarted);
      logic [22:0] ea;
      chk("R2", {inst, " opcode"}, op, 8'h3B);
      chk("R2", {inst, " address"}, ad, a);
      chk("R3", {inst, " sck period x10ns"}, longint'(gap * 10.0), div * 50);
      chk("R4", {inst, " line release errors"}, oe_err, 0);
      chk("R7", {inst, " bytes delivered"}, got, n);
      chk("R8", {inst, " rising edges under select"}, rises, 40 + 4 * n);
      chk(restarted ? "R11" : "R8", {inst, " selects"}, sel_delta, 1);
      chk("R9", {inst, " done pulses"}, donec, 1);
      chk("R12", {inst, " idle sck"}, sck_now, idle_hi);
      chk("R9", {inst, " cs_n after burst"}, csn_now, 1'b1);
      for (int i = 0; i < n && i < 64; i++) begin
         ea = a[22:0] + 23'(i);
         chk((int'(a[22:0]) + i > 23'h7FFFFF) ? "R8" : "R5", {inst, " byte"}, b[i], tb_mem_byte(ea));
      end
   endtask

   task automatic run_burst(input logic [23:0] a, input int n, input int mode, input bit restart);
      logic [7:0] b0 [64];
      logic [7:0] b1 [64];
      int got0 = 0, got1 = 0, dc0 = 0, dc1 = 0, s0, s1, tail = 0;
      s0 = m0.selects; s1 = m1.selects;
      m0.min_gap = 1.0e9; m1.min_gap = 1.0e9;
      foreach (b0[i]) begin b0[i] = '0; b1[i] = '0; end
      @(negedge clk);
      start = 1'b1; start_addr = a; byte_count = 16'(n); rd_ready = 1'b1;
      for (int k = 0; k < 30000; k++) begin
         @(negedge clk);
         start = restart && (k == 40);
         if (restart && k == 40) begin
            start_addr = a ^ 24'h00FF00; byte_count = 16'(n + 1);
         end
         case (mode)
            1: rd_ready = k[0];
            2: rd_ready = (k % 16) >= 12;
            default: rd_ready = 1'b1;
         endcase
         if (dc0 > 0 && dc1 > 0) rd_ready = 1'b1;
         if (valid0 && rd_ready) begin if (got0 < 64) b0[got0] = data0; got0++; end
         if (valid1 && rd_ready) begin if (got1 < 64) b1[got1] = data1; got1++; end
         if (done0) dc0++;
         if (done1) dc1++;
         if (dc0 > 0 && dc1 > 0) begin
            tail++;
            if (tail > 8) break;
         end
      end
      verify("mode0", DIV0, 1'b0, a, n, got0, dc0, b0, m0.selects - s0, m0.op, m0.addr,
             m0.rises, m0.oe_err, m0.min_gap, sck0, csn0, restart);
      verify("mode3", DIV1, 1'b1, a, n, got1, dc1, b1, m1.selects - s1, m1.op, m1.addr,
             m1.rises, m1.oe_err, m1.min_gap, sck1, csn1, restart);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         tests++; fails++;
         $display("FAIL R9 watchdog: actual no completion expected done");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int s0, s1;
      rst_n = 1'b0; start = 1'b0; start_addr = '0; byte_count = '0; rd_ready = 1'b1;
      repeat (4) @(negedge clk);
      chk("R1", "cs_n in reset", {csn0, csn1}, 2'b11);
      chk("R1", "oe in reset", {oe0, oe1}, 2'b00);
      chk("R12", "sck idle in reset", {sck0, sck1}, 2'b01);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1", "busy/done/valid after reset", {busy0, done0, valid0, busy1, done1, valid1}, 6'b0);
      chk("R1", "cs_n after reset", {csn0, csn1}, 2'b11);

      for (int i = 0; i < 6; i++)
         run_burst(VECS[i][39:16], int'(VECS[i][15:0]), int'(VECS[i][41:40]), 1'b0);

      // R11: start pulsed again in mid-command
      run_burst(24'h200100, 6, 0, 1'b1);

      // R10: zero-length request
      s0 = m0.selects; s1 = m1.selects;
      @(negedge clk);
      start = 1'b1; byte_count = '0; start_addr = 24'h000010;
      @(negedge clk);
      start = 1'b0;
      chk("R10", "done after zero count", {done0, done1}, 2'b11);
      chk("R10", "cs_n after zero count", {csn0, csn1}, 2'b11);
      @(negedge clk);
      chk("R10", "done single cycle", {done0, done1}, 2'b00);
      chk("R10", "no select for zero count", (m0.selects - s0) + (m1.selects - s1), 0);

      // R7: long back-pressure across a wrap
      run_burst(24'h7FFFFA, 12, 2, 1'b0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule